// File: doc/BRIEF.md
# DMA Data Width Alignment Unit

This block sits between the read phase and the write phase of a DMA channel. It takes the 32-bit word returned by the read, selects the source item of 8, 16 or 32 bits from it, and converts that item to the destination width. It then builds the 32-bit bus write word together with its byte strobes.

Narrowing keeps the low bits of the item. Widening fills the upper bits with zeros. A write to memory places the item in the byte lanes picked by the low destination address bits and sets only those strobes. A write to a peripheral port is always a full-word access. For that case a narrow destination item is copied into every lane of the word, and all four strobes are set.

A small state machine holds the result for one cycle. It has three states. In ST_IDLE no result is pending. ST_WRITE presents a converted write. ST_FAULT flags a reserved size code. The transitions are the same from every state: a sampled `in_valid` with legal size codes goes to ST_WRITE, a sampled `in_valid` with a reserved code goes to ST_FAULT, and no `in_valid` goes to ST_IDLE. Back-to-back requests stay in ST_WRITE, one result per cycle.

Top module: `dwa_align_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no request, `wr_valid`, `cfg_err`, `wr_strb` and `wr_data` are all zero.
- R2: A request sampled on a rising edge while `in_valid` is high produces its result (`wr_valid` or `cfg_err`) for exactly the cycle after that edge. With no request sampled, both stay low.
- R3: For a memory source (`src_periph`=0), the source item is read from the byte lanes chosen by `src_lane`. An 8-bit item uses lane `src_lane`, where lane n is bits 8n+7..8n. A 16-bit item uses the half-word at lane `{src_lane[1],0}`. A 32-bit item uses the whole word.
- R4: Size codes are 00 for 8 bits, 01 for 16 bits, 10 for 32 bits and 11 reserved. When the source is narrower than the destination, the item is zero-extended (0x13 from 8 to 16 bits gives 0x0013).
- R5: When the source is wider than the destination, only the low destination-width bits are kept (0xABCDEF12 to 8 bits gives 0x12, and 32 to 16 bits keeps bits 15..0).
- R6: For a memory destination (`dst_periph`=0), the item is shifted to lane offset `dst_lane` (8-bit) or `{dst_lane[1],0}` (16-bit) or 0 (32-bit). `wr_strb` bit n is set exactly for the lanes the item occupies.
- R7: For a peripheral destination with 8-bit size, the item is copied into all four byte lanes (0xAB gives 0xABABABAB).
- R8: For a peripheral destination with 16-bit size, the item is copied into both half-words (0xABCD gives 0xABCDABCD).
- R9: For a peripheral destination with 32-bit size, the item is written zero-extended to 32 bits (a 16-bit 0xABCD gives 0x0000ABCD). Every peripheral write has `wr_strb`=1111.
- R10: If either size code is 11, `cfg_err` is high in the result cycle, `wr_valid` stays low and `wr_strb` is 0000.
- R11: For a peripheral source (`src_periph`=1), the item is always taken from lane 0 upward, and `src_lane` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Read data and controls are valid this cycle |
| rd_data | input | 32 | Word returned by the read phase |
| src_size | input | 2 | Source item size code |
| dst_size | input | 2 | Destination item size code |
| src_periph | input | 1 | Source is a full-word peripheral port |
| dst_periph | input | 1 | Destination is a full-word peripheral port |
| src_lane | input | 2 | Low bits of the source address |
| dst_lane | input | 2 | Low bits of the destination address |
| wr_valid | output | 1 | Converted write is presented this cycle |
| wr_data | output | 32 | Bus write word |
| wr_strb | output | 4 | Byte strobes, bit n enables bits 8n+7..8n |
| cfg_err | output | 1 | A reserved size code was seen on the request |

## Verification
Every result of this block is due in the single cycle that follows the rising edge that sampled the request. Both the write word with its strobes and the configuration error follow this timing. The bench changes inputs on falling edges, and one falling edge later it compares `wr_valid`, `cfg_err`, `wr_data` and `wr_strb` with values from its own model. It then checks the next cycle with `in_valid` low, to show that the result lasted only one cycle. The checker's clocked properties state the same one-cycle relation using `|=>`.

// File: rtl/dwa_pkg.sv
package dwa_pkg;

    localparam int BUS_W   = 32;
    localparam int LANES   = BUS_W / 8;
    localparam int LANE_AW = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_WRITE = 2'b01,
        ST_FAULT = 2'b10
    } state_e;

    // Lanes covered by an item of the given size, starting at lane 0
    function automatic logic [LANES-1:0] size_lanes(size_e s);
        unique case (s)
            SZ_BYTE: size_lanes = LANES'(4'b0001);
            SZ_HALF: size_lanes = LANES'(4'b0011);
            SZ_WORD: size_lanes = LANES'(4'b1111);
            default: size_lanes = '0;
        endcase
    endfunction

    // Lane offset of an item, aligned down to its own size
    function automatic logic [LANE_AW-1:0] lane_base(size_e s, logic [LANE_AW-1:0] a);
        unique case (s)
            SZ_BYTE: lane_base = a;
            SZ_HALF: lane_base = {a[LANE_AW-1:1], 1'b0};
            default: lane_base = '0;
        endcase
    endfunction

    // Expand a lane mask to a bit mask
    function automatic logic [BUS_W-1:0] lane_bits(logic [LANES-1:0] m);
        for (int i = 0; i < LANES; i++) lane_bits[8*i +: 8] = {8{m[i]}};
    endfunction

endpackage

// File: rtl/dwa_extract.sv
module dwa_extract
    import dwa_pkg::*;
(
    input  logic [BUS_W-1:0]   rd_data,
    input  size_e              src_size,
    input  logic               src_periph,
    input  logic [LANE_AW-1:0] src_lane,
    output logic [BUS_W-1:0]   item
);
    logic [LANE_AW-1:0] base;
    logic [BUS_W-1:0]   shifted;

    always_comb begin
        base    = src_periph ? '0 : lane_base(src_size, src_lane);
        shifted = rd_data >> {base, 3'b000};
        item    = shifted & lane_bits(size_lanes(src_size));
    end
endmodule

// File: rtl/dwa_pack.sv
module dwa_pack
    import dwa_pkg::*;
(
    input  logic [BUS_W-1:0]   item,
    input  size_e              dst_size,
    input  logic               dst_periph,
    input  logic [LANE_AW-1:0] dst_lane,
    output logic [BUS_W-1:0]   data,
    output logic [LANES-1:0]   strb
);
    logic [BUS_W-1:0]   fitted;
    logic [LANE_AW-1:0] base;

    always_comb begin
        fitted = item & lane_bits(size_lanes(dst_size));
        base   = lane_base(dst_size, dst_lane);
        if (dst_periph) begin
            strb = '1;
            unique case (dst_size)
                SZ_BYTE: data = {LANES{fitted[7:0]}};
                SZ_HALF: data = {(LANES/2){fitted[15:0]}};
                default: data = fitted;
            endcase
        end else begin
            data = fitted << {base, 3'b000};
            strb = size_lanes(dst_size) << base;
        end
    end
endmodule

// File: rtl/dwa_align_unit.sv
module dwa_align_unit
    import dwa_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] rd_data,
    input  logic [1:0]  src_size,
    input  logic [1:0]  dst_size,
    input  logic        src_periph,
    input  logic        dst_periph,
    input  logic [1:0]  src_lane,
    input  logic [1:0]  dst_lane,
    output logic        wr_valid,
    output logic [31:0] wr_data,
    output logic [3:0]  wr_strb,
    output logic        cfg_err
);
    state_e           state, next_state;
    logic [BUS_W-1:0] item, pk_data, data_q;
    logic [LANES-1:0] pk_strb, strb_q;
    logic             bad_cfg;

    assign bad_cfg = (size_e'(src_size) == SZ_RSVD) || (size_e'(dst_size) == SZ_RSVD);

    dwa_extract u_extract (
        .rd_data    (rd_data),
        .src_size   (size_e'(src_size)),
        .src_periph (src_periph),
        .src_lane   (src_lane),
        .item       (item)
    );

    dwa_pack u_pack (
        .item       (item),
        .dst_size   (size_e'(dst_size)),
        .dst_periph (dst_periph),
        .dst_lane   (dst_lane),
        .data       (pk_data),
        .strb       (pk_strb)
    );

    // Next-state rule, identical from every state
    always_comb begin
        next_state = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_WRITE, ST_FAULT: begin
                if (in_valid) next_state = bad_cfg ? ST_FAULT : ST_WRITE;
            end
            default: next_state = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // Result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            strb_q <= '0;
        end else if (in_valid && !bad_cfg) begin
            data_q <= pk_data;
            strb_q <= pk_strb;
        end
    end

    // Outputs per state
    always_comb begin
        wr_valid = 1'b0;
        cfg_err  = 1'b0;
        wr_strb  = '0;
        unique case (state)
            ST_IDLE:  ;
            ST_WRITE: begin
                wr_valid = 1'b1;
                wr_strb  = strb_q;
            end
            ST_FAULT: cfg_err = 1'b1;
            default:  ;
        endcase
    end

    assign wr_data = data_q;

endmodule

// File: rtl/dwa_align_checker.sv
module dwa_align_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  src_size,
    input logic [1:0]  dst_size,
    input logic        dst_periph,
    input logic        wr_valid,
    input logic [3:0]  wr_strb,
    input logic        cfg_err
);
    logic rsvd;
    assign rsvd = (src_size == 2'b11) || (dst_size == 2'b11);

    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, cfg_err}));

    assert_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && rsvd |=> cfg_err && !wr_valid && wr_strb == 4'b0000);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !rsvd |=> wr_valid && !cfg_err);

    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !wr_valid && !cfg_err);

    assert_full_strb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !rsvd && dst_periph |=> wr_strb == 4'b1111);

    assert_byte_strb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !rsvd && !dst_periph && dst_size == 2'b00 |=> $countones(wr_strb) == 1);

    assert_half_strb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !rsvd && !dst_periph && dst_size == 2'b01 |=> $countones(wr_strb) == 2);
endmodule

bind dwa_align_unit dwa_align_checker u_chk (.*);

// File: tb/dwa_align_unit_test.sv
`timescale 1ns/1ps
module dwa_align_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic [1:0]  src_size = '0, dst_size = '0, src_lane = '0, dst_lane = '0;
    logic        src_periph = 1'b0, dst_periph = 1'b0;
    logic        wr_valid, cfg_err;
    logic [31:0] wr_data;
    logic [3:0]  wr_strb;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dwa_align_unit uut (.*);

    function automatic int nbytes(logic [1:0] s);
        return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
    endfunction

    function automatic void model(input logic [31:0] rd, input logic [1:0] ss, ds,
                                  input logic sp, dp, input logic [1:0] sl, dl,
                                  output logic [31:0] d, output logic [3:0] st);
        int sb = nbytes(ss);
        int db = nbytes(ds);
        int so = sp ? 0 : (sl / sb) * sb;
        int dof = (dl / db) * db;
        longint unsigned it = (longint'(rd) >> (8 * so)) & ((64'd1 << (8 * sb)) - 1);
        it = it & ((64'd1 << (8 * db)) - 1);
        if (dp) begin
            st = 4'hF;
            if (db == 1)      d = 32'(it) * 32'h0101_0101;
            else if (db == 2) d = 32'(it) * 32'h0001_0001;
            else              d = 32'(it);
        end else begin
            d  = 32'(it << (8 * dof));
            st = 4'(((1 << db) - 1) << dof);
        end
    endfunction

    function automatic string tag_of(logic [1:0] ss, ds, logic sp, dp);
        if (ss == 2'b11 || ds == 2'b11) return "R10";
        if (dp) return (ds == 2'b00) ? "R7" : (ds == 2'b01) ? "R8" : "R9";
        if (sp) return "R11";
        if (nbytes(ss) < nbytes(ds)) return "R4";
        if (nbytes(ss) > nbytes(ds)) return "R5";
        return "R6";
    endfunction

    task automatic check(string tag, logic [31:0] act, exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(logic [31:0] rd, logic [1:0] ss, ds, logic sp, dp,
                       logic [1:0] sl, dl, string tag);
        logic [31:0] ed;
        logic [3:0]  es;
        logic        rsv = (ss == 2'b11) || (ds == 2'b11);
        model(rd, ss, ds, sp, dp, sl, dl, ed, es);
        @(negedge clk);
        in_valid = 1'b1; rd_data = rd; src_size = ss; dst_size = ds;
        src_periph = sp; dst_periph = dp; src_lane = sl; dst_lane = dl;
        @(negedge clk);
        in_valid = 1'b0;
        rd_data = ~rd; src_lane = ~sl;
        if (rsv) begin
            check({tag, " err"}, {30'd0, cfg_err, wr_valid}, 32'd2);
            check({tag, " strb"}, {28'd0, wr_strb}, 32'd0);
        end else begin
            check({"R2 valid ", tag}, {30'd0, cfg_err, wr_valid}, 32'd1);
            check({tag, " data"}, wr_data, ed);
            check({tag, " strb"}, {28'd0, wr_strb}, {28'd0, es});
        end
        @(negedge clk);
        check("R2 one cycle", {30'd0, cfg_err, wr_valid}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (2) @(negedge clk);
        check("R1 reset", {cfg_err, wr_valid, wr_strb, wr_data[25:0]}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {cfg_err, wr_valid, wr_strb, wr_data[25:0]}, 32'd0);

        run(32'h0000_0013, 2'b00, 2'b01, 1'b0, 1'b0, 2'd0, 2'd0, "R4");
        run(32'hABCD_EF12, 2'b10, 2'b00, 1'b0, 1'b0, 2'd0, 2'd0, "R5");
        run(32'hB3B2_B1B0, 2'b10, 2'b01, 1'b0, 1'b0, 2'd0, 2'd2, "R5");
        run(32'h4433_2211, 2'b00, 2'b00, 1'b0, 1'b0, 2'd3, 2'd1, "R3");
        run(32'h4433_2211, 2'b01, 2'b01, 1'b0, 1'b0, 2'd3, 2'd3, "R6");
        run(32'h0000_00AB, 2'b00, 2'b00, 1'b0, 1'b1, 2'd0, 2'd2, "R7");
        run(32'h0000_ABCD, 2'b01, 2'b01, 1'b0, 1'b1, 2'd0, 2'd0, "R8");
        run(32'h0000_ABCD, 2'b01, 2'b10, 1'b0, 1'b1, 2'd0, 2'd0, "R9");
        run(32'h5566_7788, 2'b00, 2'b10, 1'b1, 1'b0, 2'd3, 2'd0, "R11");
        run(32'h1234_5678, 2'b11, 2'b00, 1'b0, 1'b0, 2'd0, 2'd0, "R10");
        run(32'h1234_5678, 2'b10, 2'b11, 1'b0, 1'b1, 2'd0, 2'd0, "R10");

        for (int i = 0; i < 400; i++) begin
            logic [1:0] ss = ($urandom % 8 == 0) ? 2'b11 : 2'($urandom % 3);
            logic [1:0] ds = ($urandom % 8 == 0) ? 2'b11 : 2'($urandom % 3);
            logic sp = 1'($urandom % 2);
            logic dp = 1'($urandom % 2);
            run($urandom, ss, ds, sp, dp, 2'($urandom % 4), 2'($urandom % 4),
                tag_of(ss, ds, sp, dp));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule